// File: doc/BRIEF.md
# Coprocessor Multi-Word Transfer Handshake Controller

This block sits on the coprocessor side of a processor/coprocessor interface and runs the handshake for an instruction that moves a burst of 32-bit words between memory and the coprocessor. A load moves words into the coprocessor. A store moves words out of it. The block reports its readiness to the processor as a 2-bit code on two ports. The decode port is used for the first decision about an instruction that is about to enter Execute. The execute port is used for every later cycle of that instruction. Instruction decode is reduced to two inputs: a "recognised" flag and a word count.

When a recognised instruction is issued, the block accepts it. It then busy-waits, reporting WAIT, until its internal resource is ready. After that it reports GO while two or more words remain and LAST when exactly one word remains. The processor's pass qualifier must be high before anything is committed. If the qualifier drops, the instruction is abandoned and left for the processor to reissue. Words move through two valid/ready streams. The store stream presents a word from the block's word bank. The load stream writes a word into that bank. A word moves only in a cycle where the pass qualifier is high and the execute code is GO or LAST.

Back-pressure rules: `st_valid_o` never depends on `st_ready_i`. `ld_ready_o` never depends on `ld_valid_i`. When the partner on the active stream is not ready to move a word (`st_ready_i` low for a store, `ld_valid_i` low for a load), the execute code becomes WAIT. So GO or LAST is only ever shown in a cycle where a word actually moves.

Top module: `cpx_xfer_hs`

## Requirements
- R1: After reset, both handshake ports show ABSENT (2'b10), and `st_valid_o` and `ld_ready_o` are low.
- R2: A cycle where `issue_i` is high and `recog_i` is low shows ABSENT on the decode port. The block stays idle, so the execute port shows ABSENT in the next cycle.
- R3: For a recognised issue while idle, the decode port shows WAIT (2'b00) if the resource is not ready. If it is ready, the decode port shows GO (2'b01) when `nwords_i` > 0 and LAST (2'b11) when `nwords_i` == 0. The execute port shows ABSENT whenever the block is idle.
- R4: While an instruction is active and either the resource or the stream partner is not ready, the execute port shows WAIT and no word moves.
- R5: When a word can move, the execute port shows GO if two or more words remain and LAST if exactly one word remains.
- R6: An accepted instruction moves exactly `nwords_i`+1 words (1 to 16). After the LAST word moves, the block returns to idle.
- R7: If `pass_i` is low in any active cycle, the instruction is abandoned in that cycle, no word moves, and the block returns to idle with the word bank unchanged.
- R8: A word commits only when `pass_i` is high and the execute code is GO or LAST. A load writes `ld_data_i` into bank word k, and a store presents bank word k on `st_data_o`, where k counts the words of the instruction from 0.
- R9: `st_valid_o` and `ld_ready_o` depend only on the direction, the resource and `pass_i`. While the partner stream holds back, the code stays WAIT and the same word stays presented.
- R10: A recognised issue arriving while an instruction is active shows WAIT on the decode port and is not accepted.
- R11: Synchronous active-high `rst` returns the block to idle from any state and clears the word bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction about to enter Execute |
| recog_i | input | 1 | Issued instruction is recognised |
| is_load_i | input | 1 | 1 = words into coprocessor, 0 = words out |
| nwords_i | input | 4 | Word count minus one |
| rsrc_ready_i | input | 1 | Internal resource ready |
| pass_i | input | 1 | Pass qualifier from processor |
| hs_dec_o | output | 2 | Decode-entry handshake code |
| hs_exe_o | output | 2 | Execute-continuation handshake code |
| st_data_o | output | 32 | Store word |
| st_valid_o | output | 1 | Store word valid |
| st_ready_i | input | 1 | Store word accepted |
| ld_data_i | input | 32 | Load word |
| ld_valid_i | input | 1 | Load word valid |
| ld_ready_o | output | 1 | Load word accepted by block |

## Verification
The bench builds the block with its default parameters: 32-bit words and a 4-bit count. With these values a single instruction can reach the full 16-word burst, which drives the remaining-word counter through its widest range and sweeps every address of the word bank. Load bursts are read back with store bursts, so each committed word, and each word that must not be committed, becomes visible on the store port. A pseudo-random phase mixes resource stalls, stream back-pressure and pass drops against the same reference model.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic [1:0] {
    HS_WAIT   = 2'b00,
    HS_GO     = 2'b01,
    HS_ABSENT = 2'b10,
    HS_LAST   = 2'b11
  } hs_code_t;

  // Code shown when an instruction is accepted: stall, or proceed with GO/LAST.
  function automatic hs_code_t hs_pick(input logic can_move, input logic one_left);
    if (!can_move)     return HS_WAIT;
    else if (one_left) return HS_LAST;
    else               return HS_GO;
  endfunction
endpackage

// File: rtl/cpx_seq_ctrl.sv
module cpx_seq_ctrl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             recog,
  input  logic             is_load,
  input  logic [CNT_W-1:0] nwords,
  input  logic             pass,
  input  logic             move_ok,
  output logic             active,
  output logic             load_dir,
  output logic             one_left,
  output logic [CNT_W-1:0] idx,
  output logic             beat
);
  localparam int REM_W = CNT_W + 1;

  logic             active_q;
  logic             load_q;
  logic [REM_W-1:0] rem_q;
  logic [CNT_W-1:0] idx_q;

  assign active   = active_q;
  assign load_dir = load_q;
  assign idx      = idx_q;
  assign one_left = (rem_q == REM_W'(1));
  assign beat     = active_q & pass & move_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      load_q   <= 1'b0;
      rem_q    <= '0;
      idx_q    <= '0;
    end else if (active_q) begin
      if (!pass) begin
        active_q <= 1'b0;
      end else if (move_ok) begin
        rem_q <= rem_q - REM_W'(1);
        idx_q <= idx_q + CNT_W'(1);
        if (one_left) active_q <= 1'b0;
      end
    end else if (issue && recog) begin
      active_q <= 1'b1;
      load_q   <= is_load;
      rem_q    <= {1'b0, nwords} + REM_W'(1);
      idx_q    <= '0;
    end
  end
endmodule

// File: rtl/cpx_word_bank.sv
module cpx_word_bank #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                              words[i] <= '0;
      else if (we && addr == ADDR_W'(i))    words[i] <= wdata;
    end
  end

  assign rdata = words[addr];
endmodule

// File: rtl/cpx_xfer_hs.sv
module cpx_xfer_hs #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic              recog_i,
  input  logic              is_load_i,
  input  logic [CNT_W-1:0]  nwords_i,
  input  logic              rsrc_ready_i,
  input  logic              pass_i,
  output logic [1:0]        hs_dec_o,
  output logic [1:0]        hs_exe_o,
  output logic [WORD_W-1:0] st_data_o,
  output logic              st_valid_o,
  input  logic              st_ready_i,
  input  logic [WORD_W-1:0] ld_data_i,
  input  logic              ld_valid_i,
  output logic              ld_ready_o
);
  import cpx_pkg::*;

  logic             active, load_dir, one_left, beat, move_ok;
  logic [CNT_W-1:0] idx;
  hs_code_t         dec_code, exe_code;

  assign move_ok = rsrc_ready_i & (load_dir ? ld_valid_i : st_ready_i);

  cpx_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue_i),
    .recog    (recog_i),
    .is_load  (is_load_i),
    .nwords   (nwords_i),
    .pass     (pass_i),
    .move_ok  (move_ok),
    .active   (active),
    .load_dir (load_dir),
    .one_left (one_left),
    .idx      (idx),
    .beat     (beat)
  );

  cpx_word_bank #(.WORD_W(WORD_W), .ADDR_W(CNT_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (beat & load_dir),
    .addr  (idx),
    .wdata (ld_data_i),
    .rdata (st_data_o)
  );

  always_comb begin
    if (!issue_i || !recog_i) dec_code = HS_ABSENT;
    else if (active)          dec_code = HS_WAIT;
    else                      dec_code = hs_pick(rsrc_ready_i, nwords_i == '0);
  end

  always_comb begin
    if (!active) exe_code = HS_ABSENT;
    else         exe_code = hs_pick(move_ok, one_left);
  end

  assign hs_dec_o   = dec_code;
  assign hs_exe_o   = exe_code;
  assign st_valid_o = active & ~load_dir & rsrc_ready_i & pass_i;
  assign ld_ready_o = active &  load_dir & rsrc_ready_i & pass_i;
endmodule

// File: rtl/cpx_xfer_hs_chk.sv
module cpx_xfer_hs_chk (
  input logic       clk,
  input logic       rst,
  input logic       issue_i,
  input logic       recog_i,
  input logic       pass_i,
  input logic [1:0] hs_exe_o,
  input logic       st_valid_o,
  input logic       st_ready_i,
  input logic       ld_valid_i,
  input logic       ld_ready_o
);
  localparam logic [1:0] C_WAIT = 2'b00;
  localparam logic [1:0] C_GO   = 2'b01;
  localparam logic [1:0] C_ABS  = 2'b10;
  localparam logic [1:0] C_LAST = 2'b11;

  p_unrec_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !recog_i && hs_exe_o == C_ABS) |=> hs_exe_o == C_ABS);

  p_wait_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (hs_exe_o == C_WAIT && pass_i) |=> hs_exe_o != C_ABS);

  p_go_continues_r5: assert property (@(posedge clk) disable iff (rst)
    (hs_exe_o == C_GO && pass_i) |=> hs_exe_o != C_ABS);

  p_last_ends_r6: assert property (@(posedge clk) disable iff (rst)
    (hs_exe_o == C_LAST && pass_i) |=> hs_exe_o == C_ABS);

  p_abandon_r7: assert property (@(posedge clk) disable iff (rst)
    (hs_exe_o != C_ABS && !pass_i) |=> hs_exe_o == C_ABS);

  p_load_commit_r8: assert property (@(posedge clk) disable iff (rst)
    (ld_ready_o && ld_valid_i) |-> (pass_i && (hs_exe_o == C_GO || hs_exe_o == C_LAST)));

  p_one_stream_r8: assert property (@(posedge clk) disable iff (rst)
    !(st_valid_o && ld_ready_o));

  p_backpressure_r9: assert property (@(posedge clk) disable iff (rst)
    (st_valid_o && !st_ready_i) |-> hs_exe_o == C_WAIT);
endmodule

bind cpx_xfer_hs cpx_xfer_hs_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .issue_i    (issue_i),
  .recog_i    (recog_i),
  .pass_i     (pass_i),
  .hs_exe_o   (hs_exe_o),
  .st_valid_o (st_valid_o),
  .st_ready_i (st_ready_i),
  .ld_valid_i (ld_valid_i),
  .ld_ready_o (ld_ready_o)
);

// File: tb/tb_cpx_xfer_hs.sv
module tb_cpx_xfer_hs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0, recog = 1'b0, is_load = 1'b0;
  logic [3:0]  nwords = '0;
  logic        rsrc = 1'b0, pass = 1'b0;
  logic [1:0]  hs_dec, hs_exe;
  logic [31:0] st_data;
  logic        st_valid, st_ready = 1'b0;
  logic [31:0] ld_data = '0;
  logic        ld_valid = 1'b0, ld_ready;

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  bit          m_active = 0, m_load = 0;
  int          m_rem = 0, m_idx = 0;
  logic [31:0] m_bank [16];

  always #4 clk = ~clk;

  cpx_xfer_hs dut (
    .clk(clk), .rst(rst), .issue_i(issue), .recog_i(recog), .is_load_i(is_load),
    .nwords_i(nwords), .rsrc_ready_i(rsrc), .pass_i(pass),
    .hs_dec_o(hs_dec), .hs_exe_o(hs_exe), .st_data_o(st_data),
    .st_valid_o(st_valid), .st_ready_i(st_ready), .ld_data_i(ld_data),
    .ld_valid_i(ld_valid), .ld_ready_o(ld_ready)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // Codes: ABSENT 10, WAIT 00, GO 01, LAST 11
  function automatic logic [1:0] pick(bit can_move, bit one);
    if (!can_move) return 2'b00;
    return one ? 2'b11 : 2'b01;
  endfunction

  // One cycle: called just after a negedge with inputs set.
  task automatic step();
    logic [1:0] e_dec, e_exe;
    bit ok;
    #1;
    ok = rsrc && (m_load ? ld_valid : st_ready);
    if (!issue || !recog)  e_dec = 2'b10;          // R2
    else if (m_active)     e_dec = 2'b00;          // R10
    else                   e_dec = pick(rsrc, nwords == 0); // R3
    e_exe = m_active ? pick(ok, m_rem == 1) : 2'b10;         // R4 R5
    chk("hs_dec", 32'(hs_dec), 32'(e_dec));
    chk("hs_exe", 32'(hs_exe), 32'(e_exe));
    chk("st_valid", 32'(st_valid), 32'(m_active && !m_load && rsrc && pass)); // R9
    chk("ld_ready", 32'(ld_ready), 32'(m_active && m_load && rsrc && pass));
    if (m_active && !m_load) chk("st_data", st_data, m_bank[m_idx]);          // R8
    @(posedge clk);
    if (rst) begin                                   // R11
      m_active = 0; m_load = 0; m_rem = 0; m_idx = 0;
      foreach (m_bank[i]) m_bank[i] = '0;
    end else if (m_active) begin
      if (!pass) m_active = 0;                       // R7
      else if (ok) begin
        if (m_load) m_bank[m_idx] = ld_data;
        m_rem--; m_idx++;
        if (m_rem == 0) m_active = 0;                // R6
      end
    end else if (issue && recog) begin
      m_active = 1; m_load = is_load; m_rem = int'(nwords) + 1; m_idx = 0;
    end
    @(negedge clk);
  endtask

  task automatic start(bit ld, int n);
    issue = 1; recog = 1; is_load = ld; nwords = 4'(n);
    step();
    issue = 0; recog = 0;
  endtask

  // Run until model idle, feeding load data and full readiness.
  task automatic drain(int salt);
    for (int k = 0; k < 40 && m_active; k++) begin
      ld_data = 32'hC0DE0000 ^ (32'(salt) << 8) ^ 32'(k * 32'h01010101);
      step();
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    foreach (m_bank[i]) m_bank[i] = '0;
    @(negedge clk);
    // R1: reset state
    cur_req = "R1"; rst = 1; step(); step(); rst = 0; step();
    // R2: unrecognised issue
    cur_req = "R2"; issue = 1; recog = 0; step(); issue = 0; step(); step();
    // R3 R5 R6 R8: 4-word load, then read back by store
    cur_req = "R3"; rsrc = 1; pass = 1; ld_valid = 1; st_ready = 1;
    start(1, 3); cur_req = "R5"; drain(1);
    cur_req = "R8"; start(0, 3); drain(0); step();
    // R3 R5: single word, LAST at once
    cur_req = "R3"; start(1, 0); cur_req = "R5"; drain(2); step();
    // R4: busy-wait for resource
    cur_req = "R4"; rsrc = 0; start(1, 2);
    for (int k = 0; k < 4; k++) step();
    rsrc = 1; drain(3);
    // R7: pass drops in busy-wait; bank must stay unchanged
    cur_req = "R7"; rsrc = 0; start(1, 5); step(); step(); pass = 0; step(); step();
    pass = 1; rsrc = 1; start(0, 5); drain(0);
    // R7: pass drops mid-transfer
    start(1, 6); step(); step(); pass = 0; step(); pass = 1; step();
    start(0, 6); drain(0);
    // R9: store back-pressure
    cur_req = "R9"; start(0, 3);
    for (int k = 0; k < 10 && m_active; k++) begin st_ready = k[0]; step(); end
    st_ready = 1; drain(0);
    // R4: load partner holds back
    cur_req = "R4"; start(1, 2);
    for (int k = 0; k < 8 && m_active; k++) begin ld_valid = (k % 3 == 2); ld_data = 32'(k) ^ 32'h5A5A0000; step(); end
    ld_valid = 1; drain(4);
    // R10: issue while active
    cur_req = "R10"; start(1, 4); start(0, 0); start(0, 1); drain(5); step();
    // R6: full 16-word burst both ways
    cur_req = "R6"; start(1, 15); drain(6); start(0, 15); drain(0);
    // R11: reset mid-transfer
    cur_req = "R11"; start(1, 7); step(); step(); rst = 1; step(); rst = 0; step();
    start(0, 15); drain(0);
    // mixed pseudo-random traffic
    cur_req = "R8";
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 600; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        issue = lf[0]; recog = lf[1] | lf[2]; is_load = lf[3]; nwords = lf[7:4];
        rsrc = lf[8] | lf[9]; pass = (lf[15:11] != 0);
        ld_valid = lf[10] | lf[11]; st_ready = lf[12] | lf[13];
        ld_data = {lf, lf ^ 16'h3C3C};
        step();
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule